// File: doc/BRIEF.md
# Overcurrent Shutdown Fault Sequencer

This block is the digital core of a fast overcurrent protection path for a three-phase half-bridge gate driver. A synchronous comparator flag reports that the sensed current is above its reference. After a programmable glitch filter, a qualified trip kills all high-side and low-side gate outputs at once and pulls an active-low fault flag. It then runs a two-phase disable timer. The first phase stands in for the discharge of the external timing node. The second phase stands in for its recharge, and it may only begin once the sensed current has dropped below the reference minus its hysteresis.

The discharge and recharge durations are cycle counts taken at the moment of the trip. This keeps the reaction time independent of the disable time. A supply-undervoltage flag disables the comparator path, and while it is present it also holds the outputs off and the fault flag low. An indicator shows when the modelled discharge switch on the timing node is conducting.

Top module: `ocp_shutdown_seq`

## Requirements
- R1: After synchronous reset the sequencer is idle: `kill_o`=0, `fault_n_o`=1, `od_discharge_o`=0, and the gate outputs equal the gate inputs.
- R2: Let N = `filt_len_i`, with 0 treated as 1. While `uv_i`=0, `cmp_trip_i` must be high at N consecutive rising edges to cause a shutdown. `kill_o` is then high in the cycle after the Nth such edge. A shorter pulse has no effect.
- R3: While `kill_o`=1, all `gate_lo_o` and `gate_hi_o` bits are 0, and `fault_n_o` is low in exactly the same cycles as `kill_o` is high.
- R4: The discharge phase lasts U+1 cycles, where U is `unlatch_len_i`; a value of 0 gives one cycle.
- R5: The recharge phase starts at the first edge at which the discharge phase is complete and `cmp_clear_i`=1. It then lasts R+1 cycles, where R is `restart_len_i`. For a trip at edge N, with recharge starting at edge E, `kill_o` is high for E+R+1−N cycles.
- R6: When the recharge phase expires, `kill_o` falls and `fault_n_o` rises. From then on the gate outputs follow the gate inputs.
- R7: While `uv_i`=1, no trip is accepted. `kill_o`=1 and `fault_n_o`=0 in the same cycle as `uv_i`=1. Once `uv_i` falls with no trip pending, the outputs are released at once.
- R8: A qualified trip during the recharge phase returns the sequencer to the discharge phase with a fresh discharge count.
- R9: U and R are captured when the trip is accepted. Later changes to `unlatch_len_i` or `restart_len_i` do not alter the sequence that is running.
- R10: `od_discharge_o` is high exactly during the discharge phase and the wait for `cmp_clear_i`. That is E−N cycles for a trip at edge N with recharge starting at edge E.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_trip_i | input | 1 | Sense above reference |
| cmp_clear_i | input | 1 | Sense below reference minus hysteresis |
| uv_i | input | 1 | Supply undervoltage present |
| filt_len_i | input | FILT_W (4) | Glitch filter length in cycles |
| unlatch_len_i | input | CNT_W (8) | Discharge phase count |
| restart_len_i | input | CNT_W (8) | Recharge phase count |
| gate_lo_i | input | NUM_PH (3) | Low-side gate commands, active high |
| gate_hi_i | input | NUM_PH (3) | High-side gate commands, active high |
| gate_lo_o | output | NUM_PH (3) | Masked low-side gate drives |
| gate_hi_o | output | NUM_PH (3) | Masked high-side gate drives |
| kill_o | output | 1 | Global output kill |
| fault_n_o | output | 1 | Fault flag, active low |
| od_discharge_o | output | 1 | Timing-node discharge switch on |

## Verification
`kill_o`, `fault_n_o`, `od_discharge_o` and the masked gates all come from the state register. A trip accepted at an edge is therefore visible before the next edge, and so is each phase change. The undervoltage effect on `kill_o` and `fault_n_o`, and the gate masking, are combinational and due in the same cycle. The bench changes inputs on the falling clock edge and samples on the following falling edge. Each sample thus reflects exactly one more rising edge. The expected first-kill sample, kill length and discharge length come from the formulas N, E+R+1−N and E−N, with E = max(N+U+1, P+C+1), where P is the length of the trip pulse and C is the delay of the clear after it.

// File: rtl/ocp_seq_pkg.sv
// Shared types for the overcurrent shutdown sequencer.
package ocp_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_FILTER     = 3'd1,
        ST_UNLATCH    = 3'd2,
        ST_WAIT_CLEAR = 3'd3,
        ST_RESTART    = 3'd4
    } seq_state_t;
endpackage

// File: rtl/ocp_glitch_filter.sv
// Counts consecutive cycles of a qualified trip and flags the cycle in which
// the run length reaches the programmed filter length (0 treated as 1).
// Assumes: qual_i is synchronous; the count saturates and clears when qual_i drops.
module ocp_glitch_filter #(
    parameter int FILT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              qual_i,
    input  logic [FILT_W-1:0] len_i,
    output logic              trig_o
);
    logic [FILT_W-1:0] run_q;
    logic [FILT_W:0]   eff_len;

    // Effective length: zero behaves as one cycle.
    always_comb eff_len = (len_i == '0) ? {{FILT_W{1'b0}}, 1'b1} : {1'b0, len_i};

    // Trip fires when this qualified cycle completes the required run.
    always_comb trig_o = qual_i && (({1'b0, run_q} + 1'b1) >= eff_len);

    // Run-length counter, saturating, cleared when the trip is not qualified.
    always_ff @(posedge clk) begin
        if (!rst_n || !qual_i)
            run_q <= '0;
        else if (run_q != '1)
            run_q <= run_q + 1'b1;
    end
endmodule

// File: rtl/ocp_phase_timer.sv
// Loadable down-counter shared by the discharge and recharge phases.
// Assumes: a load takes priority; the counter stops at zero.
module ocp_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] val_i,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt_q;

    // Load on request, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= val_i;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    // Expiry flag for the phase in progress.
    always_comb zero_o = (cnt_q == '0);
endmodule

// File: rtl/ocp_gate_mask.sv
// Forces one half-bridge's pair of gate drives low while the kill is active.
// Assumes: kill_i is glitch-free (from a register or a synchronous flag).
module ocp_gate_mask (
    input  logic lo_i,
    input  logic hi_i,
    input  logic kill_i,
    output logic lo_o,
    output logic hi_o
);
    // Pass commands through only when not killed.
    always_comb begin
        lo_o = lo_i & ~kill_i;
        hi_o = hi_i & ~kill_i;
    end
endmodule

// File: rtl/ocp_shutdown_seq.sv
// Overcurrent shutdown sequencer: glitch filter, immediate latched kill, then a
// discharge phase and a recharge phase that waits for the sense to clear.
// Assumes: all inputs synchronous to clk; undervoltage disables trip qualification.
module ocp_shutdown_seq
    import ocp_seq_pkg::*;
#(
    parameter int NUM_PH = 3,
    parameter int FILT_W = 4,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_trip_i,
    input  logic              cmp_clear_i,
    input  logic              uv_i,
    input  logic [FILT_W-1:0] filt_len_i,
    input  logic [CNT_W-1:0]  unlatch_len_i,
    input  logic [CNT_W-1:0]  restart_len_i,
    input  logic [NUM_PH-1:0] gate_lo_i,
    input  logic [NUM_PH-1:0] gate_hi_i,
    output logic [NUM_PH-1:0] gate_lo_o,
    output logic [NUM_PH-1:0] gate_hi_o,
    output logic              kill_o,
    output logic              fault_n_o,
    output logic              od_discharge_o
);
    seq_state_t       state_q, state_d;
    logic             qual, trig, t_zero, accept;
    logic             t_load;
    logic [CNT_W-1:0] t_val;
    logic [CNT_W-1:0] rst_hold_q;
    logic             fault_active;

    // Trip is only qualified outside undervoltage.
    always_comb qual = cmp_trip_i & ~uv_i;

    ocp_glitch_filter #(.FILT_W(FILT_W)) u_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .qual_i (qual),
        .len_i  (filt_len_i),
        .trig_o (trig)
    );

    // A trip is accepted only where the sequencer is listening for one.
    always_comb accept = trig && (state_q == ST_IDLE || state_q == ST_FILTER
                                  || state_q == ST_RESTART);

    // Next-state logic for the five-state sequencer.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (accept) state_d = ST_UNLATCH;
                           else if (qual) state_d = ST_FILTER;
            ST_FILTER:     if (accept) state_d = ST_UNLATCH;
                           else if (!qual) state_d = ST_IDLE;
            ST_UNLATCH:    if (t_zero) state_d = cmp_clear_i ? ST_RESTART : ST_WAIT_CLEAR;
            ST_WAIT_CLEAR: if (cmp_clear_i) state_d = ST_RESTART;
            ST_RESTART:    if (accept) state_d = ST_UNLATCH;
                           else if (t_zero) state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // Timer load: discharge count at trip, held recharge count on entering recharge.
    always_comb begin
        t_load = 1'b0;
        t_val  = unlatch_len_i;
        if (accept) begin
            t_load = 1'b1;
            t_val  = unlatch_len_i;
        end else if (state_d == ST_RESTART && state_q != ST_RESTART) begin
            t_load = 1'b1;
            t_val  = rst_hold_q;
        end
    end

    ocp_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (t_load),
        .val_i  (t_val),
        .zero_o (t_zero)
    );

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Recharge count captured at the trip instant.
    always_ff @(posedge clk) begin
        if (!rst_n)      rst_hold_q <= '0;
        else if (accept) rst_hold_q <= restart_len_i;
    end

    // Output decode: latched fault or undervoltage kills and flags.
    always_comb begin
        fault_active   = (state_q == ST_UNLATCH) || (state_q == ST_WAIT_CLEAR)
                         || (state_q == ST_RESTART);
        kill_o         = fault_active | uv_i;
        fault_n_o      = ~kill_o;
        od_discharge_o = (state_q == ST_UNLATCH) || (state_q == ST_WAIT_CLEAR);
    end

    for (genvar p = 0; p < NUM_PH; p++) begin : g_phase
        ocp_gate_mask u_mask (
            .lo_i   (gate_lo_i[p]),
            .hi_i   (gate_hi_i[p]),
            .kill_i (kill_o),
            .lo_o   (gate_lo_o[p]),
            .hi_o   (gate_hi_o[p])
        );
    end
endmodule

// File: rtl/ocp_shutdown_seq_chk.sv
// Property checker for the overcurrent shutdown sequencer, bound to the top.
module ocp_shutdown_seq_chk
    import ocp_seq_pkg::*;
#(
    parameter int NUM_PH = 3
) (
    input logic              clk,
    input logic              rst_n,
    input seq_state_t        state_q,
    input logic              cmp_trip_i,
    input logic              cmp_clear_i,
    input logic              uv_i,
    input logic              kill_o,
    input logic              fault_n_o,
    input logic              od_discharge_o,
    input logic [NUM_PH-1:0] gate_lo_o,
    input logic [NUM_PH-1:0] gate_hi_o
);
    AST_GATES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        kill_o |-> (gate_lo_o == '0 && gate_hi_o == '0)); // R3

    AST_NO_TRIP_WITHOUT_CMP: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE || state_q == ST_FILTER) && !cmp_trip_i)
        |=> state_q != ST_UNLATCH); // R2

    AST_UV_NO_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE || state_q == ST_FILTER) && uv_i)
        |=> (state_q == ST_IDLE || state_q == ST_FILTER)); // R7

    AST_RESTART_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_UNLATCH || state_q == ST_WAIT_CLEAR) && !cmp_clear_i)
        |=> state_q != ST_RESTART); // R5

    AST_RETRIP_NEEDS_CMP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RESTART && !cmp_trip_i) |=> state_q != ST_UNLATCH); // R8

    AST_OD_WITH_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        od_discharge_o |-> (kill_o && !fault_n_o)); // R10
endmodule

bind ocp_shutdown_seq ocp_shutdown_seq_chk #(.NUM_PH(NUM_PH)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .state_q        (state_q),
    .cmp_trip_i     (cmp_trip_i),
    .cmp_clear_i    (cmp_clear_i),
    .uv_i           (uv_i),
    .kill_o         (kill_o),
    .fault_n_o      (fault_n_o),
    .od_discharge_o (od_discharge_o),
    .gate_lo_o      (gate_lo_o),
    .gate_hi_o      (gate_hi_o)
);

// File: tb/ocp_shutdown_seq_bench.sv
module ocp_shutdown_seq_bench;
    localparam int NPH = 3;
    localparam int WIN = 60;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmp_trip = 1'b0, cmp_clear = 1'b1, uv = 1'b0;
    logic [3:0] filt_len = 4'd2;
    logic [7:0] unl_len = 8'd0, rst_len = 8'd0;
    logic [2:0] glo = 3'b101, ghi = 3'b010;
    logic [2:0] glo_o, ghi_o;
    logic       kill, fault_n, od;
    int         n_chk = 0, n_fail = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    ocp_shutdown_seq u_ocp_shutdown_seq (
        .clk(clk), .rst_n(rst_n), .cmp_trip_i(cmp_trip), .cmp_clear_i(cmp_clear),
        .uv_i(uv), .filt_len_i(filt_len), .unlatch_len_i(unl_len),
        .restart_len_i(rst_len), .gate_lo_i(glo), .gate_hi_i(ghi),
        .gate_lo_o(glo_o), .gate_hi_o(ghi_o), .kill_o(kill),
        .fault_n_o(fault_n), .od_discharge_o(od)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // {filt, pulse P, clear delay C, U, R}
    localparam logic [39:0] VEC [8] = '{
        {8'd3, 8'd2,  8'd0,  8'd2, 8'd4},
        {8'd3, 8'd3,  8'd0,  8'd2, 8'd4},
        {8'd0, 8'd1,  8'd0,  8'd0, 8'd0},
        {8'd1, 8'd1,  8'd10, 8'd1, 8'd3},
        {8'd4, 8'd9,  8'd2,  8'd3, 8'd6},
        {8'd5, 8'd4,  8'd0,  8'd1, 8'd1},
        {8'd2, 8'd2,  8'd0,  8'd7, 8'd12},
        {8'd6, 8'd20, 8'd0,  8'd1, 8'd2}
    };

    // One trip scenario; U2/R2 are applied after the first edge (R9).
    task automatic run_case(input int f, input int p, input int c, input int u,
                            input int r, input int u2, input int r2);
        int n, er, kcnt, ocnt, first, bad;
        n = (f == 0) ? 1 : f;
        er = (n + u + 1 > p + c + 1) ? n + u + 1 : p + c + 1;
        kcnt = 0; ocnt = 0; first = 0; bad = 0;
        filt_len = 4'(f); unl_len = 8'(u); rst_len = 8'(r);
        for (int k = 1; k <= WIN; k++) begin
            cmp_trip  = (k <= p);
            cmp_clear = (k >= p + c + 1);
            if (k >= 2) begin unl_len = 8'(u2); rst_len = 8'(r2); end
            @(negedge clk);
            if (kill) begin
                kcnt++;
                if (first == 0) first = k;
                if (glo_o != 3'b000 || ghi_o != 3'b000) bad++;
            end else if (glo_o != glo || ghi_o != ghi) bad++;
            if (fault_n == kill) bad++;
            if (od) ocnt++;
        end
        if (p >= n) begin
            check("R2 first kill sample", first, n);
            check("R5/R4 kill length", kcnt, er + r + 1 - n);
            check("R10 discharge length", ocnt, er - n);
        end else begin
            check("R2 short pulse ignored", kcnt, 0);
        end
        check("R3/R6 gate mask and fault flag", bad, 0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 kill", kill, 0); check("R1 fault_n", fault_n, 1);
        check("R1 od", od, 0);     check("R1 gates", {glo_o, ghi_o}, {glo, ghi});
        rst_n = 1'b1;
        @(negedge clk);
        foreach (VEC[i]) begin
            run_case(VEC[i][39:32], VEC[i][31:24], VEC[i][23:16], VEC[i][15:8],
                     VEC[i][7:0], VEC[i][15:8], VEC[i][7:0]);
        end
        // R9: lengths changed after the trip is accepted
        run_case(1, 1, 0, 2, 3, 30, 30);
        // R7: undervoltage holds off trips and forces kill
        filt_len = 4'd2; uv = 1'b1; cmp_trip = 1'b1; cmp_clear = 1'b0;
        #1;
        check("R7 kill with uv same cycle", kill, 1);
        check("R7 fault_n with uv", fault_n, 0);
        repeat (10) @(negedge clk);
        cmp_trip = 1'b0; cmp_clear = 1'b1;
        @(negedge clk);
        uv = 1'b0;
        #1;
        check("R7 released after uv", kill, 0);
        @(negedge clk);
        check("R7 no latched trip", kill, 0);
        // R8: re-trip during recharge. filt=2 U=1 R=20; trip at edges 1,2.
        filt_len = 4'd2; unl_len = 8'd1; rst_len = 8'd20;
        for (int k = 1; k <= 34; k++) begin
            cmp_trip  = (k <= 2) || (k == 8) || (k == 9);
            cmp_clear = !((k <= 2) || (k == 8) || (k == 9));
            @(negedge clk);
            if (k == 7)  check("R8 in recharge, od low", od, 0);
            if (k == 9)  check("R8 re-trip back to discharge", od, 1);
            if (k == 26) check("R8 kill extended past first expiry", kill, 1);
            if (k == 31) check("R8 kill before new expiry", kill, 1);
            if (k == 32) check("R8 kill released after new expiry", kill, 0);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule